// File: doc/BRIEF.md
# BCD Latch Seven-Segment Decoder

This block turns a 4-bit BCD digit into seven active-high segment drives for a common-cathode display. A digit register sits at the input. While the load control is low, the register follows the incoming digit. While the control is high, the register keeps the digit it last captured. This lets a shared data bus update several displays in turn.

Two active-low controls act on the output stage only. A lamp test forces every segment on, and it wins over everything else. A blank input forces every segment off. The stored codes ten to fifteen also produce a dark display. The block is fully synchronous: the digit register and a segment register each add one clock of delay.

Top module: `bcd_seg_latch_decoder`

## Requirements
- R1: When `lamp_test_ni` is low at a clock edge, `seg_o` is 7'b1111111 after that edge. This holds whatever the other inputs are.
- R2: When `lamp_test_ni` is high and `blank_ni` is low at a clock edge, `seg_o` is 7'b0000000 after that edge.
- R3: At a clock edge where `latch_en_i` is low, the digit register takes `bcd_i`. At an edge where `latch_en_i` is high, it keeps its value.
- R4: With both overrides released, a stored code from 4'b1010 to 4'b1111 gives `seg_o` = 7'b0000000.
- R5: With both overrides released, stored digits 0 to 9 give these `seg_o` values, written as a b c d e f g with bit 6 = a and bit 0 = g:
  - 0 → 1111110, 1 → 0110000, 2 → 1101101, 3 → 1111001, 4 → 0110011
  - 5 → 1011011, 6 → 0011111, 7 → 1110000, 8 → 1111111, 9 → 1110011
  - The 6 is drawn without segment a, and the 9 without segment d.
- R6: The overrides never change the stored digit. Once both are released with the register holding, the display shows the held digit again.
- R7: While `rst_ni` is low, the digit register is 4'b0000 and `seg_o` is 7'b0000000.
- R8: In transparent mode, a change on `bcd_i` reaches `seg_o` two clock edges later. A change on an override reaches `seg_o` one edge later.

Encoding of `bcd_i`: bit 3 is the most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bcd_i | input | 4 | BCD digit, bit 3 is the most significant bit |
| latch_en_i | input | 1 | Low: digit register loads. High: digit register holds |
| lamp_test_ni | input | 1 | Active-low lamp test, lights all segments |
| blank_ni | input | 1 | Active-low blank, turns all segments off |
| seg_o | output | 7 | Segments a..g as bits 6..0, active high |

## Verification
A corrupted stored digit stays hidden while an override is active. It shows up one edge after both overrides are released, either as a wrong digit pattern or as a wrong blank. For this reason the bench releases the overrides after every held digit and checks the display there.

A wrong load or hold decision moves the display off the expected digit two edges after the input changes. An override that leaks into the digit register shows up on the first edge after release. All sixteen codes are run against every combination of the three controls, so a single-bit error in the decode table appears within one code sweep.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;
  localparam int unsigned MAX_DIGIT = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;

  localparam seg_t SEG_ALL_ON  = {SEG_W{1'b1}};
  localparam seg_t SEG_ALL_OFF = '0;
endpackage

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg
  import seg7_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  digit_t bcd_i,
  input  logic   latch_en_i,
  output digit_t code_o
);
  digit_t code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          code_q <= '0;
    else if (!latch_en_i) code_q <= bcd_i;
  end

  assign code_o = code_q;

  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_en_i |=> $stable(code_q)) else $error("hold changed code"); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_en_i |=> code_q == $past(bcd_i)) else $error("load missed"); // R3
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import seg7_pkg::*;
(
  input  digit_t code_i,
  output seg_t   seg_o
);
  always_comb begin
    unique case (code_i)
      4'd0:    seg_o = 7'b1111110;
      4'd1:    seg_o = 7'b0110000;
      4'd2:    seg_o = 7'b1101101;
      4'd3:    seg_o = 7'b1111001;
      4'd4:    seg_o = 7'b0110011;
      4'd5:    seg_o = 7'b1011011;
      4'd6:    seg_o = 7'b0011111; // no top bar
      4'd7:    seg_o = 7'b1110000;
      4'd8:    seg_o = 7'b1111111;
      4'd9:    seg_o = 7'b1110011; // no bottom bar
      default: seg_o = SEG_ALL_OFF;
    endcase
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg7_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  seg_t seg_i,
  input  logic lamp_test_ni,
  input  logic blank_ni,
  output seg_t seg_o
);
  seg_t seg_d, seg_q;

  // lamp test wins over blank
  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    assign seg_d[s] = !lamp_test_ni | (blank_ni & seg_i[s]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_q <= SEG_ALL_OFF;
    else         seg_q <= seg_d;
  end

  assign seg_o = seg_q;

  AST_LAMP_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lamp_test_ni |=> seg_o == SEG_ALL_ON) else $error("lamp test"); // R1
  AST_BLANK_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && !blank_ni) |=> seg_o == SEG_ALL_OFF) else $error("blank"); // R2
endmodule

// File: rtl/bcd_seg_latch_decoder.sv
module bcd_seg_latch_decoder
  import seg7_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] bcd_i,
  input  logic       latch_en_i,
  input  logic       lamp_test_ni,
  input  logic       blank_ni,
  output logic [6:0] seg_o
);
  digit_t code;
  seg_t   seg_dec;

  bcd_digit_reg u_digit (
    .clk_i(clk_i), .rst_ni(rst_ni), .bcd_i(bcd_i),
    .latch_en_i(latch_en_i), .code_o(code)
  );

  seg_decode u_dec (.code_i(code), .seg_o(seg_dec));

  seg_out_stage u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .seg_i(seg_dec),
    .lamp_test_ni(lamp_test_ni), .blank_ni(blank_ni), .seg_o(seg_o)
  );

  AST_ILLEGAL_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && blank_ni && code > digit_t'(MAX_DIGIT)) |=> seg_o == SEG_ALL_OFF)
    else $error("illegal code lit"); // R4
  AST_RESET_DARK: assert property (@(posedge clk_i)
    !rst_ni |-> (seg_o == SEG_ALL_OFF && code == '0)) else $error("reset state"); // R7
endmodule

// File: tb/bcd_seg_latch_decoder_tb.sv
module bcd_seg_latch_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bcd = '0;
  logic le = 1'b0, lt_n = 1'b1, bl_n = 1'b1;
  logic [6:0] seg;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [6:0] exp; string tag; } item_t;
  item_t q[$];
  logic [3:0] m_code = '0;
  bit m_held = 1'b0;

  always #4 clk = ~clk;

  bcd_seg_latch_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bcd_i(bcd), .latch_en_i(le),
    .lamp_test_ni(lt_n), .blank_ni(bl_n), .seg_o(seg)
  );

  function automatic logic [6:0] ref_pat(logic [3:0] c);
    case (c)
      4'd0: return 7'b1111110;  4'd1: return 7'b0110000;
      4'd2: return 7'b1101101;  4'd3: return 7'b1111001;
      4'd4: return 7'b0110011;  4'd5: return 7'b1011011;
      4'd6: return 7'b0011111;  4'd7: return 7'b1110000;
      4'd8: return 7'b1111111;  4'd9: return 7'b1110011;
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic step(input logic [3:0] c, input logic l, input logic t, input logic b,
                      input string tag = "");
    item_t it;
    @(negedge clk);
    bcd = c; le = l; lt_n = t; bl_n = b;
    it.exp = !t ? 7'h7f : (!b ? 7'h00 : ref_pat(m_code));
    if (tag != "")    it.tag = tag;
    else if (!t)      it.tag = "R1";
    else if (!b)      it.tag = "R2";
    else if (m_held)  it.tag = "R3";
    else if (m_code > 9) it.tag = "R4";
    else              it.tag = "R5";
    q.push_back(it);
    if (!l) m_code = c;
    m_held = l;
  endtask

  // monitor
  initial begin
    item_t it;
    wait (rst_n);
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (seg !== it.exp) begin
          errors++;
          $display("FAIL %s: seg_o=%b expected %b", it.tag, seg, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL R8 watchdog: seg_o=%b expected run to end", seg);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (seg !== 7'b0) begin
      errors++;
      $display("FAIL R7: seg_o=%b expected %b", seg, 7'b0);
    end
    rst_n = 1'b1;
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 8; m++) begin
        logic [2:0] mm;
        mm = 3'(m);
        step(4'((c + 7) % 16), 1'b0, 1'b1, 1'b1);
        step(4'(c), mm[2], mm[1], mm[0]);
        step(4'(c), 1'b1, 1'b1, 1'b1);
      end
    end
    // R6: overrides leave held digit intact
    step(4'd5, 1'b0, 1'b1, 1'b1);
    step(4'd9, 1'b1, 1'b0, 1'b1, "R6");
    step(4'd9, 1'b1, 1'b1, 1'b0, "R6");
    step(4'd9, 1'b1, 1'b0, 1'b0, "R6");
    step(4'd9, 1'b1, 1'b1, 1'b1, "R6");
    step(4'd9, 1'b1, 1'b1, 1'b1, "R6");
    // R8: two-edge data latency, one-edge override latency
    step(4'd2, 1'b0, 1'b1, 1'b1);
    step(4'd8, 1'b0, 1'b1, 1'b1, "R8");
    step(4'd8, 1'b0, 1'b0, 1'b1, "R8");
    step(4'd8, 1'b0, 1'b1, 1'b1, "R8");
    step(4'd8, 1'b0, 1'b1, 1'b1, "R8");
    wait (q.size() == 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule